// File: doc/BRIEF.md
# Input Power Source Arbiter

This block picks the input that feeds the system rail and the battery charger, and the setting that governs the charge rate. It works from clean digital presence flags for a wall adapter and a USB port, a priority-select pin, a charge enable, a USB rate pin and a power-up pulse. It drives three path enables (adapter switch, USB switch, battery-only) and two small codes that name the charge source and the rate source.

The priority pin reverses the preference between the two inputs. It also decides whether the adapter charges at its resistor-programmed rate or at the USB rate chosen by the rate pin. A start-up window of `BOOT_CYC` clock cycles forces charging on at the low USB rate, whatever the enable and rate pins say. The window is honoured only while USB is the preferred input. It restarts after reset, on a power-up pulse, or when an input appears after a time with none present.

The path enables are registered. Whenever the selected path changes, all three are dropped for one clock before the new one is raised, so two switches are never on together and every handoff takes exactly two clocks.

Top module: `pwr_src_arbiter`

## Requirements
- R1: With `prio_adp`=1 and enable effective, the adapter is used when present (`chg_src`=01, `rate_src`=01 programmed); otherwise USB is used when present, with `rate_src`=10 when `rate_hi`=0 and 11 when `rate_hi`=1 (`chg_src`=10).
- R2: With `prio_adp`=0 and enable effective, USB is used when present (`chg_src`=10). Otherwise the adapter is used (`chg_src`=01), and in both cases `rate_src` follows `rate_hi` (10 or 11).
- R3: With neither input present, `path_bat`=1, `chg_src`=00 and `rate_src`=00.
- R4: With an input present, `chg_en`=0 and no start-up window active, `path_bat`=1, `chg_src`=00 and `rate_src`=00.
- R5: While the start-up window runs and `prio_adp`=0 with an input present, `boot_act`=1, charging proceeds even if `chg_en`=0, and `rate_src`=10 whatever `rate_hi` is. When the window ends, `boot_act` falls and the pins apply again.
- R6: `boot_act` stays 0 while `prio_adp`=1 or no input is present, even inside the window.
- R7: At most one of `path_adp`, `path_usb` and `path_bat` is 1. On a change of path, all three are 0 for exactly one clock, and the new path is asserted on the second rising edge after the input change.
- R8: While `rst_n`=0, all outputs are 0.
- R9: A change of `rate_hi` or `chg_src` that keeps the same path appears at the outputs after one rising edge, with no gap on the path enables.
- R10: A one-cycle `pwr_up` pulse restarts the start-up window for a full `BOOT_CYC` cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prio_adp | input | 1 | 1: adapter preferred, 0: USB preferred |
| adp_ok | input | 1 | Adapter present (deglitched) |
| usb_ok | input | 1 | USB present (deglitched) |
| chg_en | input | 1 | Charge enable; 0 means standby on battery |
| rate_hi | input | 1 | USB rate select: 0 low, 1 high |
| pwr_up | input | 1 | Power-up pulse that restarts the start-up window |
| path_adp | output | 1 | Adapter switch enable |
| path_usb | output | 1 | USB switch enable |
| path_bat | output | 1 | Battery-only path enable |
| chg_src | output | 2 | Charge source: 00 none, 01 adapter, 10 USB |
| rate_src | output | 2 | Rate source: 00 none, 01 programmed, 10 USB low, 11 USB high |
| boot_act | output | 1 | Start-up override in effect |

## Verification
The hardest case to reach is the start-up override acting on a live input. Reset happens with inputs already present, and the vector table avoids any new input arrival, so the window is long gone before the table runs. The bench therefore first parks both inputs absent, then raises USB with the enable low, which restarts the window. It also fires a power-up pulse while the adapter is preferred and then flips the priority inside that window. The bench is built with a short `BOOT_CYC`, which keeps both the start and the end of the window within reach.

// File: rtl/pwr_arb_pkg.sv
package pwr_arb_pkg;
  typedef enum logic [2:0] {
    PATH_OFF = 3'b000,
    PATH_ADP = 3'b001,
    PATH_USB = 3'b010,
    PATH_BAT = 3'b100
  } path_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'b00,
    SRC_ADP  = 2'b01,
    SRC_USB  = 2'b10
  } src_e;

  typedef enum logic [1:0] {
    RATE_NONE   = 2'b00,
    RATE_PROG   = 2'b01,
    RATE_USB_LO = 2'b10,
    RATE_USB_HI = 2'b11
  } rate_e;
endpackage

// File: rtl/boot_window_timer.sv
module boot_window_timer #(
  parameter int BOOT_CYC = 150000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic any_in,
  input  logic restart_req,
  output logic run_o
);
  localparam int CW = $clog2(BOOT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(BOOT_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d;
  logic          seen_q;
  logic          start;
  logic          cnt_en;

  // restart on absent->present transition or explicit power-up pulse
  assign start  = (any_in & ~seen_q) | restart_req;
  assign cnt_en = start | run_q;

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    if (start) begin
      cnt_d = '0;
      run_d = 1'b1;
    end else if (run_q) begin
      if (cnt_q == LAST) run_d = 1'b0;
      else               cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      run_q  <= 1'b1;
      seen_q <= 1'b0;
    end else begin
      seen_q <= any_in;
      if (cnt_en) begin
        cnt_q <= cnt_d;
        run_q <= run_d;
      end
    end
  end

  assign run_o = run_q;
endmodule

// File: rtl/source_select.sv
module source_select
  import pwr_arb_pkg::*;
(
  input  logic  prio_adp,
  input  logic  adp_ok,
  input  logic  usb_ok,
  input  logic  chg_en,
  input  logic  rate_hi,
  input  logic  boot_run,
  output path_e tgt_path,
  output src_e  tgt_src,
  output rate_e tgt_rate,
  output logic  boot_live
);
  logic  any_ok;
  logic  en_eff;
  rate_e pin_rate;

  assign any_ok    = adp_ok | usb_ok;
  assign boot_live = boot_run & ~prio_adp & any_ok;
  assign en_eff    = chg_en | boot_live;
  assign pin_rate  = rate_hi ? RATE_USB_HI : RATE_USB_LO;

  always_comb begin
    tgt_path = PATH_BAT;
    tgt_src  = SRC_NONE;
    tgt_rate = RATE_NONE;
    if (any_ok && en_eff) begin
      if (prio_adp) begin
        if (adp_ok) begin
          tgt_path = PATH_ADP;
          tgt_src  = SRC_ADP;
          tgt_rate = RATE_PROG;
        end else begin
          tgt_path = PATH_USB;
          tgt_src  = SRC_USB;
          tgt_rate = pin_rate;
        end
      end else begin
        if (usb_ok) begin
          tgt_path = PATH_USB;
          tgt_src  = SRC_USB;
        end else begin
          tgt_path = PATH_ADP;
          tgt_src  = SRC_ADP;
        end
        tgt_rate = boot_live ? RATE_USB_LO : pin_rate;
      end
    end
  end
endmodule

// File: rtl/path_sequencer.sv
module path_sequencer
  import pwr_arb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  path_e tgt_path,
  input  src_e  tgt_src,
  input  rate_e tgt_rate,
  input  logic  boot_live,
  output path_e path_q,
  output src_e  src_q,
  output rate_e rate_q,
  output logic  boot_q
);
  path_e path_d;
  src_e  src_d;
  rate_e rate_d;

  always_comb begin
    if (tgt_path == path_q) begin
      path_d = path_q;
      src_d  = tgt_src;
      rate_d = tgt_rate;
    end else if (path_q != PATH_OFF) begin
      // break before make: open every switch for one clock
      path_d = PATH_OFF;
      src_d  = SRC_NONE;
      rate_d = RATE_NONE;
    end else begin
      path_d = tgt_path;
      src_d  = tgt_src;
      rate_d = tgt_rate;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      path_q <= PATH_OFF;
      src_q  <= SRC_NONE;
      rate_q <= RATE_NONE;
      boot_q <= 1'b0;
    end else begin
      path_q <= path_d;
      src_q  <= src_d;
      rate_q <= rate_d;
      boot_q <= boot_live;
    end
  end
endmodule

// File: rtl/pwr_src_arbiter.sv
module pwr_src_arbiter
  import pwr_arb_pkg::*;
#(
  parameter int BOOT_CYC = 150000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       prio_adp,
  input  logic       adp_ok,
  input  logic       usb_ok,
  input  logic       chg_en,
  input  logic       rate_hi,
  input  logic       pwr_up,
  output logic       path_adp,
  output logic       path_usb,
  output logic       path_bat,
  output logic [1:0] chg_src,
  output logic [1:0] rate_src,
  output logic       boot_act
);
  logic  boot_run;
  logic  boot_live;
  path_e tgt_path, path_q;
  src_e  tgt_src, src_q;
  rate_e tgt_rate, rate_q;

  boot_window_timer #(.BOOT_CYC(BOOT_CYC)) u_boot (
    .clk         (clk),
    .rst_n       (rst_n),
    .any_in      (adp_ok | usb_ok),
    .restart_req (pwr_up),
    .run_o       (boot_run)
  );

  source_select u_sel (
    .prio_adp  (prio_adp),
    .adp_ok    (adp_ok),
    .usb_ok    (usb_ok),
    .chg_en    (chg_en),
    .rate_hi   (rate_hi),
    .boot_run  (boot_run),
    .tgt_path  (tgt_path),
    .tgt_src   (tgt_src),
    .tgt_rate  (tgt_rate),
    .boot_live (boot_live)
  );

  path_sequencer u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tgt_path  (tgt_path),
    .tgt_src   (tgt_src),
    .tgt_rate  (tgt_rate),
    .boot_live (boot_live),
    .path_q    (path_q),
    .src_q     (src_q),
    .rate_q    (rate_q),
    .boot_q    (boot_act)
  );

  assign path_adp = path_q[0];
  assign path_usb = path_q[1];
  assign path_bat = path_q[2];
  assign chg_src  = src_q;
  assign rate_src = rate_q;
endmodule

// File: rtl/pwr_src_arbiter_chk.sv
module pwr_src_arbiter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       prio_adp,
  input logic       path_adp,
  input logic       path_usb,
  input logic       path_bat,
  input logic [1:0] chg_src,
  input logic [1:0] rate_src,
  input logic       boot_act
);
  logic [2:0] pv;
  assign pv = {path_bat, path_usb, path_adp};

  // R7
  path_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pv));

  // R7
  break_before_make_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pv != 3'b000) && ($past(pv) != 3'b000)) |-> (pv == $past(pv)));

  // R7
  handoff_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pv == 3'b000) |=> (pv != 3'b000));

  // R3
  charge_needs_input_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_src != 2'b00) |-> (!path_bat && rate_src != 2'b00));

  // R5
  boot_low_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_act && chg_src != 2'b00) |-> (rate_src == 2'b10));

  // R1
  prog_rate_adp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_src == 2'b01) |-> (chg_src == 2'b01 && $past(prio_adp)));

  // R6
  boot_prio_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boot_act |-> !$past(prio_adp));
endmodule

bind pwr_src_arbiter pwr_src_arbiter_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .prio_adp (prio_adp),
  .path_adp (path_adp),
  .path_usb (path_usb),
  .path_bat (path_bat),
  .chg_src  (chg_src),
  .rate_src (rate_src),
  .boot_act (boot_act)
);

// File: tb/sim_pwr_src_arbiter.sv
module sim_pwr_src_arbiter;
  localparam int CLK_P = 10;
  localparam int BOOT  = 16;

  logic clk = 1'b0;
  logic rst_n, prio_adp, adp_ok, usb_ok, chg_en, rate_hi, pwr_up;
  logic path_adp, path_usb, path_bat, boot_act;
  logic [1:0] chg_src, rate_src;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  pwr_src_arbiter #(.BOOT_CYC(BOOT)) u0 (
    .clk(clk), .rst_n(rst_n), .prio_adp(prio_adp), .adp_ok(adp_ok),
    .usb_ok(usb_ok), .chg_en(chg_en), .rate_hi(rate_hi), .pwr_up(pwr_up),
    .path_adp(path_adp), .path_usb(path_usb), .path_bat(path_bat),
    .chg_src(chg_src), .rate_src(rate_src), .boot_act(boot_act)
  );

  // {prio, adp, usb, en, rate_hi, path{bat,usb,adp}, src, rate}
  localparam logic [11:0] VEC [12] = '{
    {5'b11110, 3'b001, 2'b01, 2'b01},  // R1 adapter wins
    {5'b10111, 3'b010, 2'b10, 2'b11},  // R1 USB fallback high
    {5'b10110, 3'b010, 2'b10, 2'b10},  // R1 USB fallback low
    {5'b11011, 3'b001, 2'b01, 2'b01},  // R1 adapter, pin ignored
    {5'b01111, 3'b010, 2'b10, 2'b11},  // R2 USB wins
    {5'b01010, 3'b001, 2'b01, 2'b10},  // R2 adapter at USB low
    {5'b01011, 3'b001, 2'b01, 2'b11},  // R2 adapter at USB high
    {5'b00110, 3'b010, 2'b10, 2'b10},  // R2 USB only
    {5'b00101, 3'b100, 2'b00, 2'b00},  // R4 standby
    {5'b11100, 3'b100, 2'b00, 2'b00},  // R4 standby
    {5'b10010, 3'b100, 2'b00, 2'b00},  // R3 no input
    {5'b00011, 3'b100, 2'b00, 2'b00}   // R3 no input
  };

  function automatic logic [6:0] outs();
    return {path_bat, path_usb, path_adp, chg_src, rate_src};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; prio_adp = 1'b1; adp_ok = 1'b1; usb_ok = 1'b1;
    chg_en = 1'b1; rate_hi = 1'b0; pwr_up = 1'b0;
    cyc(3);
    // R8 reset state
    chk("R8", {1'b0, outs()}, 8'h00);
    rst_n = 1'b1;
    cyc(BOOT + 14);

    for (int i = 0; i < 12; i++) begin
      string tag;
      {prio_adp, adp_ok, usb_ok, chg_en, rate_hi} = VEC[i][11:7];
      cyc(3);
      tag = (i < 4) ? "R1" : (i < 8) ? "R2" : (i < 10) ? "R4" : "R3";
      chk(tag, {1'b0, outs()}, {1'b0, VEC[i][6:0]});
      chk("R6", {7'b0, boot_act}, 8'h00);
    end

    // R5: USB appears after none present, enable low -> window restarts
    prio_adp = 1'b0; usb_ok = 1'b1; adp_ok = 1'b0; chg_en = 1'b0; rate_hi = 1'b1;
    cyc(4);
    chk("R5", {boot_act, outs()}, {1'b1, 3'b010, 2'b10, 2'b10});
    cyc(BOOT + 4);
    chk("R5", {boot_act, outs()}, {1'b0, 3'b100, 2'b00, 2'b00});

    // R6 / R10: power-up pulse while adapter preferred
    prio_adp = 1'b1; adp_ok = 1'b1; usb_ok = 1'b0;
    pwr_up = 1'b1;
    cyc(1);
    pwr_up = 1'b0;
    cyc(2);
    chk("R6", {boot_act, outs()}, {1'b0, 3'b100, 2'b00, 2'b00});
    prio_adp = 1'b0;
    cyc(3);
    chk("R10", {boot_act, outs()}, {1'b1, 3'b001, 2'b01, 2'b10});
    cyc(BOOT + 4);

    // R7: break-before-make gap on priority flip
    prio_adp = 1'b1; adp_ok = 1'b1; usb_ok = 1'b1; chg_en = 1'b1; rate_hi = 1'b0;
    cyc(4);
    chk("R7", {1'b0, outs()}, {1'b0, 3'b001, 2'b01, 2'b01});
    prio_adp = 1'b0;
    cyc(1);
    chk("R7", {1'b0, outs()}, 8'h00);
    cyc(1);
    chk("R7", {1'b0, outs()}, {1'b0, 3'b010, 2'b10, 2'b10});

    // R9: rate pin change on a held path, one edge, no gap
    rate_hi = 1'b1;
    cyc(1);
    chk("R9", {1'b0, outs()}, {1'b0, 3'b010, 2'b10, 2'b11});

    done = 1'b1;
    finish_run();
  end
endmodule